// File: doc/BRIEF.md
# Per-Core Local Reset Sequencer

This block places one processor core of a multi-core device in a local reset and takes it back out. The rest of the chip is not affected. Software controls the reset through a single run bit in a small register port. A watchdog can also force the reset through a dedicated request input. While the core is held, the sequencer counts fixed intervals and raises two completion flags, one for module reset and one for local reset. Software polls these flags before it prepares the next start.

The block also holds a boot-entry register. The value written there is kept through any number of local resets. On the clock edge that releases the core, the value is copied to the boot vector output with its low ten bits cleared. This lets software restart the core at an address of its own choosing without running the boot ROM again. Only a device-level reset clears the control state and puts back the default ROM entry. The memory-access enable stays high during local reset, so the core's local memories can still be reached from the system side.

Top module: `core_lrst_ctrl`

## Requirements
- R1: While `rstDevN` is low, `coreRstN` is 0. After `rstDevN` rises, `coreRstN` stays 0 and `memAccessEn` is 1 from the first clock edge. The registers read as follows:
  - control (address 0) reads 0;
  - status (address 1) reads 0;
  - boot-entry (address 2) reads 0x20B00001;
  - `bootVector` is 0x20B00000.
- R2: A write to address 0 with bit 0 = 0 drives `coreRstN` low at that clock edge. A write with bit 0 = 1 drives it high at that edge. Control bit 0 reads back the run state.
- R3: `memAccessEn` does not drop while the core is in local reset.
- R4: Status bit 1 (module reset done) reads 1 once 4 clock edges have passed after the edge that asserted reset. Status bit 0 (local reset done) reads 1 once 8 edges have passed. Both bits read 0 from the release edge onward.
- R5: On the release edge, `bootVector` takes the boot-entry register value with bits 9:0 forced to zero.
- R6: A write to the boot-entry register (address 2) while the core is running leaves `bootVector` unchanged until the next release.
- R7: The boot-entry register keeps its value through local resets, whether software or the watchdog started them.
- R8: A high `wdogReq` drives `coreRstN` low at the next edge, even if a run write arrives in the same cycle. It also sets the sticky watchdog-cause flag, status bit 2. After that, a run write releases the core and the flag stays set.
- R9: Only a device-level reset clears status bit 2 and brings back the default boot-entry value.
- R10: Writes to the status address do not change the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstDevN | input | 1 | Device-level reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 status, 2 boot entry) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| wdogReq | input | 1 | Watchdog request for local reset |
| coreRstN | output | 1 | Core reset, active low |
| memAccessEn | output | 1 | Local memory access enable |
| bootVector | output | 32 | Aligned fetch address presented to the core |

## Verification
The bench uses the default parameters: a 4-cycle module-done interval, an 8-cycle local-done interval and a 10-bit alignment. With these values, every cycle of the completion window can be checked one by one. Random boot addresses exercise the forced low bits, and random hold lengths stop the reset before, at and after each threshold. Directed cases cover the watchdog racing a run write and a device reset that follows a watchdog event.

// File: rtl/lrst_pkg.sv
package lrst_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] regAddr_t;

  localparam regAddr_t ADDR_CTRL = 2'd0;
  localparam regAddr_t ADDR_STAT = 2'd1;
  localparam regAddr_t ADDR_BOOT = 2'd2;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic bootWr;
    logic releaseStb;
    logic runQ;
    logic locDone;
    logic modDone;
    logic wdogFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/lrst_ctrl.sv
module lrst_ctrl
  import lrst_pkg::*;
#(
  parameter int LOC_DONE_CYCLES = 8,
  parameter int MOD_DONE_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rstDevN,
  input  logic         regWrEn,
  input  regAddr_t     regAddr,
  input  logic         runBit,
  input  logic         wdogReq,
  output ctrlStrobes_t strb,
  output logic         coreRstN,
  output logic         memAccessEn
);
  localparam int CNT_W = $clog2(LOC_DONE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOC_LIM = CNT_W'(LOC_DONE_CYCLES);
  localparam logic [CNT_W-1:0] MOD_LIM = CNT_W'(MOD_DONE_CYCLES);

  logic runQ, runNext, wdogQ, memEnQ;
  logic [CNT_W-1:0] holdCnt;
  logic ctrlWr;

  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);

  // watchdog has priority over a software run write
  always_comb begin
    runNext = runQ;
    if (wdogReq)     runNext = 1'b0;
    else if (ctrlWr) runNext = runBit;
  end

  always_ff @(posedge clk or negedge rstDevN) begin
    if (!rstDevN) begin
      runQ    <= 1'b0;
      wdogQ   <= 1'b0;
      memEnQ  <= 1'b0;
      holdCnt <= '0;
    end else begin
      runQ   <= runNext;
      memEnQ <= 1'b1;
      if (wdogReq) wdogQ <= 1'b1;
      if (runQ)                  holdCnt <= '0;
      else if (holdCnt != LOC_LIM) holdCnt <= holdCnt + 1'b1;
    end
  end

  assign strb.bootWr     = regWrEn && (regAddr == ADDR_BOOT);
  assign strb.releaseStb = !runQ && runNext;
  assign strb.runQ       = runQ;
  assign strb.locDone    = !runQ && (holdCnt == LOC_LIM);
  assign strb.modDone    = !runQ && (holdCnt >= MOD_LIM);
  assign strb.wdogFlag   = wdogQ;

  assign coreRstN    = runQ;
  assign memAccessEn = memEnQ;
endmodule

// File: rtl/lrst_datapath.sv
module lrst_datapath
  import lrst_pkg::*;
#(
  parameter int                ALIGN_BITS   = 10,
  parameter logic [DATA_W-1:0] BOOT_DEFAULT = 32'h20B0_0001
) (
  input  logic              clk,
  input  logic              rstDevN,
  input  ctrlStrobes_t      strb,
  input  regAddr_t          regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] bootVector
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = {DATA_W{1'b1}} << ALIGN_BITS;
  localparam logic [DATA_W-1:0] VEC_DEFAULT = BOOT_DEFAULT & ALIGN_MASK;

  logic [DATA_W-1:0] bootQ, vecQ;

  always_ff @(posedge clk or negedge rstDevN) begin
    if (!rstDevN) begin
      bootQ <= BOOT_DEFAULT;
      vecQ  <= VEC_DEFAULT;
    end else begin
      if (strb.bootWr)     bootQ <= regWrData;
      if (strb.releaseStb) vecQ  <= bootQ & ALIGN_MASK;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: regRdData[0] = strb.runQ;
      ADDR_STAT: regRdData[2:0] = {strb.wdogFlag, strb.modDone, strb.locDone};
      ADDR_BOOT: regRdData = bootQ;
      default:   regRdData = '0;
    endcase
  end

  assign bootVector = vecQ;
endmodule

// File: rtl/core_lrst_ctrl.sv
module core_lrst_ctrl
  import lrst_pkg::*;
#(
  parameter int          LOC_DONE_CYCLES = 8,
  parameter int          MOD_DONE_CYCLES = 4,
  parameter int          ALIGN_BITS      = 10,
  parameter logic [31:0] BOOT_DEFAULT    = 32'h20B0_0001
) (
  input  logic        clk,
  input  logic        rstDevN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        wdogReq,
  output logic        coreRstN,
  output logic        memAccessEn,
  output logic [31:0] bootVector
);
  ctrlStrobes_t strb;

  lrst_ctrl #(
    .LOC_DONE_CYCLES(LOC_DONE_CYCLES),
    .MOD_DONE_CYCLES(MOD_DONE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstDevN(rstDevN), .regWrEn(regWrEn), .regAddr(regAddr),
    .runBit(regWrData[0]), .wdogReq(wdogReq), .strb(strb),
    .coreRstN(coreRstN), .memAccessEn(memAccessEn)
  );

  lrst_datapath #(
    .ALIGN_BITS(ALIGN_BITS),
    .BOOT_DEFAULT(BOOT_DEFAULT)
  ) u_dp (
    .clk(clk), .rstDevN(rstDevN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bootVector(bootVector)
  );
endmodule

// File: rtl/core_lrst_ctrl_chk.sv
module core_lrst_ctrl_chk (
  input logic        clk,
  input logic        rstDevN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        wdogReq,
  input logic        coreRstN,
  input logic        memAccessEn,
  input logic [31:0] bootVector,
  input logic        locDone,
  input logic        wdogFlag
);
  // R3
  mem_en_hold_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    memAccessEn |=> memAccessEn);

  // R8
  wdog_rst_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    wdogReq |=> !coreRstN);

  // R8
  wdog_flag_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    wdogReq |=> wdogFlag);

  // R9
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    wdogFlag |=> wdogFlag);

  // R2
  release_cause_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    $rose(coreRstN) |-> $past(regWrEn && regAddr == 2'd0 && regWrData[0] && !wdogReq));

  // R6
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    (coreRstN && $past(coreRstN)) |-> $stable(bootVector));

  // R4
  done_in_rst_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    locDone |-> !coreRstN);

  // R4
  done_after_assert_chk: assert property (@(posedge clk) disable iff (!rstDevN)
    $fell(coreRstN) |-> !locDone);
endmodule

bind core_lrst_ctrl core_lrst_ctrl_chk u_chk (
  .clk(clk), .rstDevN(rstDevN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .wdogReq(wdogReq), .coreRstN(coreRstN),
  .memAccessEn(memAccessEn), .bootVector(bootVector),
  .locDone(strb.locDone), .wdogFlag(strb.wdogFlag)
);

// File: tb/core_lrst_ctrl_tb.sv
module core_lrst_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstDevN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        wdogReq = 1'b0;
  logic        coreRstN, memAccessEn;
  logic [31:0] bootVector;

  int nTests = 0, nFail = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  core_lrst_ctrl u_dut (
    .clk(clk), .rstDevN(rstDevN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wdogReq(wdogReq),
    .coreRstN(coreRstN), .memAccessEn(memAccessEn), .bootVector(bootVector)
  );

  function automatic logic [31:0] alignOf(input logic [31:0] a);
    return {a[31:10], 10'b0};
  endfunction

  // status after k edges of hold: bit1 at >=4, bit0 at >=8
  function automatic logic [31:0] statOf(input int k, input logic cause);
    return {29'b0, cause, (k >= 4), (k >= 8)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic devReset();
    @(negedge clk);
    rstDevN = 1'b0;
    #1;
    chk("R1 core held in device reset", {31'b0, coreRstN}, 32'd0);
    repeat (2) @(negedge clk);
    rstDevN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, addr, expVec;
    logic cause;
    void'($urandom(32'd4711));

    devReset();
    // first edge after reset release
    @(negedge clk);
    chk("R1 coreRstN", {31'b0, coreRstN}, 32'd0);
    chk("R1 memAccessEn", {31'b0, memAccessEn}, 32'd1);
    rd(2'd0, v); chk("R1 control", v, 32'd0);
    rd(2'd2, v); chk("R1 boot entry", v, 32'h20B00001);
    chk("R1 bootVector", bootVector, 32'h20B00000);
    // one edge already passed since release: k = 1
    rd(2'd1, v); chk("R4 status k=1", v, statOf(1, 1'b0));
    for (int k = 2; k <= 10; k++) begin
      @(negedge clk);
      rd(2'd1, v); chk($sformatf("R4 status after device reset k=%0d", k), v, statOf(k, 1'b0));
    end

    wr(2'd0, 32'd1);
    chk("R2 release", {31'b0, coreRstN}, 32'd1);
    chk("R5 default vector", bootVector, 32'h20B00000);
    rd(2'd1, v); chk("R4 clear on release", v, 32'd0);
    rd(2'd0, v); chk("R2 run readback", v, 32'd1);

    wr(2'd1, 32'h7);
    rd(2'd1, v); chk("R10 status write ignored", v, 32'd0);

    expVec = 32'h20B00000;
    cause = 1'b0;
    addr = 32'h20B00001;
    for (int it = 0; it < 16; it++) begin
      int hold;
      addr = $urandom;
      if (it == 0) addr = 32'hFFFF_FFFF;
      wr(2'd2, addr);
      chk("R6 vector unchanged while running", bootVector, expVec);
      rd(2'd2, v); chk("R7 boot readback", v, addr);
      wr(2'd0, 32'd0);
      chk("R2 assert", {31'b0, coreRstN}, 32'd0);
      chk("R3 memAccessEn in reset", {31'b0, memAccessEn}, 32'd1);
      rd(2'd1, v); chk("R4 status k=0", v, statOf(0, cause));
      hold = $urandom_range(12, 1);
      for (int k = 1; k <= hold; k++) begin
        @(negedge clk);
        rd(2'd1, v); chk($sformatf("R4 status k=%0d", k), v, statOf(k, cause));
        chk("R3 memAccessEn held", {31'b0, memAccessEn}, 32'd1);
      end
      rd(2'd2, v); chk("R7 boot survives local reset", v, addr);
      wr(2'd0, 32'd1);
      expVec = alignOf(addr);
      chk("R2 release", {31'b0, coreRstN}, 32'd1);
      chk("R5 latched aligned vector", bootVector, expVec);
      rd(2'd1, v); chk("R4 cleared on release", v, 32'd0);
    end

    // watchdog racing a run write
    @(negedge clk);
    wdogReq = 1'b1; regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'd1;
    @(negedge clk);
    wdogReq = 1'b0; regWrEn = 1'b0;
    chk("R8 watchdog forces reset", {31'b0, coreRstN}, 32'd0);
    rd(2'd1, v); chk("R8 cause flag set", v, statOf(1, 1'b1) & 32'h4);
    repeat (3) @(negedge clk);
    chk("R8 reset held until run write", {31'b0, coreRstN}, 32'd0);
    rd(2'd2, v); chk("R7 boot survives watchdog reset", v, addr);
    wr(2'd0, 32'd1);
    chk("R8 run write releases", {31'b0, coreRstN}, 32'd1);
    chk("R5 vector after watchdog", bootVector, expVec);
    rd(2'd1, v); chk("R8 cause sticky", v, 32'h4);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R10 write cannot clear cause", v, 32'h4);

    devReset();
    @(negedge clk);
    rd(2'd1, v); chk("R9 cause cleared by device reset", v & 32'h4, 32'd0);
    rd(2'd2, v); chk("R9 boot default restored", v, 32'h20B00001);
    chk("R9 vector default restored", bootVector, 32'h20B00000);

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule